// File: doc/BRIEF.md
# Per-Instruction Stride Prefetch Table

This block watches the stream of memory accesses leaving a core and learns, separately for each load or store instruction, whether that instruction walks through memory with a repeating stride. It is a small set-associative table. Each entry is tagged by an instruction's program counter and holds the last address that instruction touched, the security attribute of that access, and a saturating confidence count.

Each clock cycle at most one access event arrives. When an instruction hits in the table with a new address, its confidence rises. Once the confidence reaches a set threshold, the difference between the new address and the remembered one is taken as the stride. The block then queues a burst of prefetch addresses one, two and further strides ahead of the current access.

Prefetch addresses leave through a small FIFO at one per cycle under a valid/ready handshake. A burst is only queued when the FIFO has room for all of it.

Top module: `stride_pf_table`

## Requirements
- R1: An event with `ev_pc_ok` low neither changes the table nor produces any prefetch. The stride computed by a later event of the same instruction is measured from the address stored before the ignored event.
- R2: An event whose PC misses in the table takes a victim way, tags it with the PC, stores the address and secure bit, and clears its confidence. It produces no prefetch.
- R3: A hit whose address differs from the stored address raises the entry's confidence by one. A burst is produced when the raised confidence is at or above THRESH (default 2). With the defaults, the first changed-address hit after allocation produces nothing and the second produces a burst.
- R4: A burst holds DIST entries (default 2), leaving in order i = 1, 2, … DIST. Entry i has the address `ev_addr + i*(ev_addr - stored_addr)` and the secure bit of the triggering event.
- R5: After a changed-address hit, the stored address and secure bit are replaced by those of that event. The next stride is measured from this event.
- R6: A hit whose address equals the stored address leaves the confidence and stored state unchanged and produces no prefetch.
- R7: The stride is a signed two's-complement value of ADDR_W bits, and prefetch addresses wrap modulo 2^ADDR_W. Both backward strides and strides across the top of the address space work.
- R8: The confidence count saturates at its maximum (3 with CNT_W = 2) rather than wrapping, so an instruction that keeps streaming keeps producing bursts.
- R9: The set index is `ev_pc[PC_ALIGN +: log2(SETS)]`. Within a set, an invalid way is filled first (lowest way first). Otherwise the least recently used way is replaced, and both hits and allocations count as uses.
- R10: The FIFO holds FIFO_DEPTH entries (default 4). A burst is dropped entirely when fewer than DIST entries are free. While `pf_valid` is high and `pf_ready` is low, the head entry and its secure bit hold steady, and one entry leaves per cycle while `pf_ready` is high.
- R11: After reset the table is empty and `pf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An access event is present this cycle |
| ev_pc_ok | input | 1 | The event carries a valid program counter |
| ev_pc | input | PC_W | Program counter of the accessing instruction |
| ev_addr | input | ADDR_W | Accessed address |
| ev_secure | input | 1 | Security attribute of the access |
| pf_valid | output | 1 | A prefetch address is offered |
| pf_ready | input | 1 | Consumer takes the offered prefetch |
| pf_addr | output | ADDR_W | Prefetch address |
| pf_secure | output | 1 | Security attribute carried with the prefetch |

## Verification
The main sequence drives one instruction through allocation, a first changed-address hit, an ignored event without a PC, and a threshold-crossing hit. Together these separate "counts before issuing" from "issues at once" and "trained by PC-less events". Repeated and changed addresses then tell a frozen entry from one that overwrites its address, and a backward stride past saturation tells saturation from wrapping. A second instruction that crosses the top of the address space with the secure bit set checks wrap-around and that the secure bit is carried through. A third instruction in the same set, followed by reuse of the survivors, tells LRU replacement from plain round-robin. A directed phase fills the FIFO with the consumer stalled, showing that a whole burst is dropped rather than split and that the head holds until drained.

// File: rtl/spt_pkg.sv
package spt_pkg;

    // Classification of one access event against the table
    typedef enum logic [1:0] {
        EV_IGNORE = 2'd0,
        EV_ALLOC  = 2'd1,
        EV_REPEAT = 2'd2,
        EV_STRIDE = 2'd3
    } ev_kind_e;

endpackage

// File: rtl/spt_lru.sv
module spt_lru #(
    parameter int WAYS = 2,
    localparam int RW  = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [RW-1:0] touch_way,
    output logic [RW-1:0] lru_way
);

    typedef struct packed {
        logic [WAYS-1:0][RW-1:0] rank;
    } lru_s;

    lru_s st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (touch) begin
            for (int w = 0; w < WAYS; w++) begin
                if (RW'(w) == touch_way) begin
                    st_d.rank[w] = '0;
                end else if (st_q.rank[w] < st_q.rank[touch_way]) begin
                    st_d.rank[w] = st_q.rank[w] + 1'b1;
                end
            end
        end
        lru_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.rank[w] == RW'(WAYS - 1)) begin
                lru_way = RW'(w);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                st_q.rank[w] <= RW'(w);
            end
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spt_fifo.sv
module spt_fifo #(
    parameter int W     = 33,
    parameter int DEPTH = 4,
    parameter int BURST = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      push,
    input  logic [BURST-1:0][W-1:0]   push_data,
    input  logic                      pop,
    output logic                      out_valid,
    output logic [W-1:0]              out_data,
    output logic [LW-1:0]             level
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [LW-1:0]           level;
    } fifo_s;

    fifo_s st_q, st_d;
    logic  pop_ok;

    always_comb begin
        st_d   = st_q;
        pop_ok = pop && (st_q.level != '0);
        if (pop_ok) begin
            st_d.rp = st_q.rp + 1'b1;
        end
        if (push) begin
            for (int i = 0; i < BURST; i++) begin
                st_d.mem[st_q.wp + PW'(i)] = push_data[i];
            end
            st_d.wp = st_q.wp + PW'(BURST);
        end
        st_d.level = st_q.level + (push ? LW'(BURST) : '0) - (pop_ok ? LW'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.level != '0);
    assign out_data  = st_q.mem[st_q.rp];
    assign level     = st_q.level;

endmodule

// File: rtl/stride_pf_table.sv
module stride_pf_table #(
    parameter int ADDR_W     = 32,
    parameter int PC_W       = 32,
    parameter int PC_ALIGN   = 2,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int CNT_W      = 2,
    parameter int THRESH     = 2,
    parameter int DIST       = 2,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic              ev_pc_ok,
    input  logic [PC_W-1:0]   ev_pc,
    input  logic [ADDR_W-1:0] ev_addr,
    input  logic              ev_secure,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              pf_secure
);

    import spt_pkg::*;

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = PC_W - IDX_W;
    localparam int RW    = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int LW    = $clog2(FIFO_DEPTH + 1);
    localparam int PF_W  = ADDR_W + 1;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] addr;
        logic              sec;
        logic [CNT_W-1:0]  cnt;
    } ent_t;

    typedef struct packed {
        ent_t [SETS-1:0][WAYS-1:0] ent;
    } tbl_t;

    tbl_t tbl_q, tbl_d;

    logic [IDX_W-1:0]            lk_set;
    logic [TAG_W-1:0]            lk_tag;
    logic                        lk_hit;
    logic                        lk_same;
    logic [RW-1:0]               hit_way;
    logic                        free_found;
    logic [RW-1:0]               free_way;
    logic [RW-1:0]               vict_way;
    ent_t                        sel_ent;
    logic [ADDR_W-1:0]           delta;
    logic [CNT_W-1:0]            cnt_inc;
    logic                        act;
    ev_kind_e                    kind;
    logic                        burst_req;
    logic                        push_en;
    logic [DIST-1:0][PF_W-1:0]   burst_data;
    logic [SETS-1:0][RW-1:0]     lru_way;
    logic [LW-1:0]               fifo_level;
    logic [PF_W-1:0]             head;

    // Lookup: index from PC bits above alignment, tag keeps the rest
    always_comb begin
        lk_set = ev_pc[PC_ALIGN +: IDX_W];
        lk_tag = {ev_pc[PC_W-1:PC_ALIGN+IDX_W], ev_pc[PC_ALIGN-1:0]};
        lk_hit  = 1'b0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (tbl_q.ent[lk_set][w].vld && (tbl_q.ent[lk_set][w].tag == lk_tag)) begin
                lk_hit  = 1'b1;
                hit_way = RW'(w);
            end
        end
        free_found = 1'b0;
        free_way   = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!tbl_q.ent[lk_set][w].vld) begin
                free_found = 1'b1;
                free_way   = RW'(w);
            end
        end
        vict_way = free_found ? free_way : lru_way[lk_set];
        sel_ent  = tbl_q.ent[lk_set][hit_way];
        lk_same  = lk_hit && (sel_ent.addr == ev_addr);
        delta    = ev_addr - sel_ent.addr;
        cnt_inc  = (&sel_ent.cnt) ? sel_ent.cnt : sel_ent.cnt + 1'b1;
        act      = ev_valid && ev_pc_ok;
        if (!act) begin
            kind = EV_IGNORE;
        end else if (!lk_hit) begin
            kind = EV_ALLOC;
        end else if (lk_same) begin
            kind = EV_REPEAT;
        end else begin
            kind = EV_STRIDE;
        end
    end

    // Burst generation and FIFO room check
    always_comb begin
        burst_req = (kind == EV_STRIDE) && (cnt_inc >= CNT_W'(THRESH));
        push_en   = burst_req && (fifo_level <= LW'(FIFO_DEPTH - DIST));
        for (int i = 0; i < DIST; i++) begin
            burst_data[i] = {ev_secure, ev_addr + ADDR_W'(i + 1) * delta};
        end
    end

    // Table next state
    always_comb begin
        tbl_d = tbl_q;
        case (kind)
            EV_ALLOC: begin
                tbl_d.ent[lk_set][vict_way].vld  = 1'b1;
                tbl_d.ent[lk_set][vict_way].tag  = lk_tag;
                tbl_d.ent[lk_set][vict_way].addr = ev_addr;
                tbl_d.ent[lk_set][vict_way].sec  = ev_secure;
                tbl_d.ent[lk_set][vict_way].cnt  = '0;
            end
            EV_STRIDE: begin
                tbl_d.ent[lk_set][hit_way].addr = ev_addr;
                tbl_d.ent[lk_set][hit_way].sec  = ev_secure;
                tbl_d.ent[lk_set][hit_way].cnt  = cnt_inc;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // One recency tracker per set
    for (genvar s = 0; s < SETS; s++) begin : g_lru
        spt_lru #(
            .WAYS (WAYS)
        ) u_lru (
            .clk       (clk),
            .rst_n     (rst_n),
            .touch     (act && (lk_set == IDX_W'(s))),
            .touch_way (lk_hit ? hit_way : vict_way),
            .lru_way   (lru_way[s])
        );
    end

    spt_fifo #(
        .W     (PF_W),
        .DEPTH (FIFO_DEPTH),
        .BURST (DIST)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_en),
        .push_data (burst_data),
        .pop       (pf_ready),
        .out_valid (pf_valid),
        .out_data  (head),
        .level     (fifo_level)
    );

    assign pf_addr   = head[ADDR_W-1:0];
    assign pf_secure = head[ADDR_W];

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int ADDR_W     = 32,
    parameter int DIST       = 2,
    parameter int FIFO_DEPTH = 4,
    localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_valid,
    input logic              ev_pc_ok,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              pf_secure,
    input logic              lk_hit,
    input logic              lk_same,
    input logic              push_en,
    input logic [LW-1:0]     fifo_level
);

    p_nopc_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_pc_ok && !pf_valid |=> !pf_valid);

    p_alloc_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_pc_ok && !lk_hit && !pf_valid |=> !pf_valid);

    p_burst_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |=> pf_valid);

    p_repeat_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_pc_ok && lk_same && !pf_valid |=> !pf_valid);

    p_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (fifo_level <= LW'(FIFO_DEPTH - DIST)));

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr) && $stable(pf_secure));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LW'(FIFO_DEPTH));

endmodule

bind stride_pf_table spt_checker #(
    .ADDR_W     (ADDR_W),
    .DIST       (DIST),
    .FIFO_DEPTH (FIFO_DEPTH)
) u_spt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (ev_valid),
    .ev_pc_ok   (ev_pc_ok),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_addr    (pf_addr),
    .pf_secure  (pf_secure),
    .lk_hit     (lk_hit),
    .lk_same    (lk_same),
    .push_en    (push_en),
    .fifo_level (fifo_level)
);

// File: tb/test_stride_pf_table.sv
module test_stride_pf_table;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ev_valid;
    logic        ev_pc_ok;
    logic [31:0] ev_pc;
    logic [31:0] ev_addr;
    logic        ev_secure;
    logic        pf_valid;
    logic        pf_ready;
    logic [31:0] pf_addr;
    logic        pf_secure;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    stride_pf_table i_stride_pf_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_valid  (ev_valid),
        .ev_pc_ok  (ev_pc_ok),
        .ev_pc     (ev_pc),
        .ev_addr   (ev_addr),
        .ev_secure (ev_secure),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr),
        .pf_secure (pf_secure)
    );

    typedef struct packed {
        logic        ok;
        logic [31:0] pc;
        logic [31:0] addr;
        logic        sec;
        logic [1:0]  n;
        logic [31:0] delta;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 32'h100, 32'h0000_1000, 1'b0, 2'd0, 32'h0},          // R2 allocate
        '{1'b1, 32'h100, 32'h0000_1040, 1'b0, 2'd0, 32'h0},          // R3 count 1
        '{1'b0, 32'h100, 32'h0000_5000, 1'b0, 2'd0, 32'h0},          // R1 no PC
        '{1'b1, 32'h100, 32'h0000_1080, 1'b0, 2'd2, 32'h40},         // R3 R4 burst
        '{1'b1, 32'h100, 32'h0000_1080, 1'b0, 2'd0, 32'h0},          // R6 repeat
        '{1'b1, 32'h100, 32'h0000_10A0, 1'b0, 2'd2, 32'h20},         // R5 new base
        '{1'b1, 32'h100, 32'h0000_1060, 1'b0, 2'd2, 32'hFFFF_FFC0},  // R7 R8 backward, saturated
        '{1'b1, 32'h200, 32'hFFFF_FFF0, 1'b1, 2'd0, 32'h0},          // R9 second way
        '{1'b1, 32'h200, 32'hFFFF_FFF8, 1'b1, 2'd0, 32'h0},          // R3
        '{1'b1, 32'h200, 32'h0000_0000, 1'b1, 2'd2, 32'h8},          // R7 wrap, R4 secure
        '{1'b1, 32'h100, 32'h0000_1070, 1'b0, 2'd2, 32'h10},         // R9 touch
        '{1'b1, 32'h300, 32'h0000_9000, 1'b0, 2'd0, 32'h0},          // R9 evicts LRU
        '{1'b1, 32'h100, 32'h0000_1078, 1'b0, 2'd2, 32'h8},          // R9 survivor
        '{1'b1, 32'h200, 32'h0000_0010, 1'b1, 2'd0, 32'h0},          // R9 victim reallocated
        '{1'b1, 32'h200, 32'h0000_0020, 1'b1, 2'd0, 32'h0}           // R9 fresh count
    };

    function automatic string req_of(int idx);
        case (idx)
            0:        return "R2";
            1, 8:     return "R3";
            2:        return "R1";
            3:        return "R4";
            4:        return "R6";
            5:        return "R5";
            6:        return "R8";
            9:        return "R7";
            default:  return "R9";
        endcase
    endfunction

    task automatic chk(input bit cond, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive_ev(input logic ok, input logic [31:0] pc,
                            input logic [31:0] addr, input logic sec);
        @(negedge clk);
        ev_valid  = 1'b1;
        ev_pc_ok  = ok;
        ev_pc     = pc;
        ev_addr   = addr;
        ev_secure = sec;
        @(negedge clk);
        ev_valid  = 1'b0;
        ev_pc_ok  = 1'b0;
    endtask

    // Runs at a negedge with pf_ready high; collects up to 'want' beats
    task automatic collect(input string req, input int want,
                           input logic [31:0] base, input logic [31:0] delta,
                           input logic sec);
        int got = 0;
        for (int k = 0; k < 4; k++) begin
            if (pf_valid) begin
                logic [31:0] e;
                e = base + 32'(got + 1) * delta;
                if (got < want) begin
                    chk(pf_addr == e, req, "prefetch address", pf_addr, e);
                    chk(pf_secure == sec, req, "prefetch secure", 32'(pf_secure), 32'(sec));
                end
                got++;
            end
            @(negedge clk);
        end
        chk(got == want, req, "prefetch count", 32'(got), 32'(want));
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        ev_valid  = 1'b0;
        ev_pc_ok  = 1'b0;
        ev_pc     = '0;
        ev_addr   = '0;
        ev_secure = 1'b0;
        pf_ready  = 1'b1;
        repeat (3) @(negedge clk);
        chk(pf_valid == 1'b0, "R11", "pf_valid in reset", 32'(pf_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pf_valid == 1'b0, "R11", "pf_valid after reset", 32'(pf_valid), 32'h0);

        // Vector walk, consumer always ready
        for (int v = 0; v < NV; v++) begin
            drive_ev(VEC[v].ok, VEC[v].pc, VEC[v].addr, VEC[v].sec);
            collect(req_of(v), int'(VEC[v].n), VEC[v].addr, VEC[v].delta, VEC[v].sec);
        end

        // R10: stalled consumer, whole-burst drop, head hold, drain order
        pf_ready = 1'b0;
        drive_ev(1'b1, 32'h404, 32'h8000, 1'b0);
        drive_ev(1'b1, 32'h404, 32'h8100, 1'b0);
        drive_ev(1'b1, 32'h404, 32'h8200, 1'b0);
        drive_ev(1'b1, 32'h404, 32'h8300, 1'b0);
        drive_ev(1'b1, 32'h404, 32'h8400, 1'b0);
        chk(pf_valid == 1'b1, "R10", "pf_valid while stalled", 32'(pf_valid), 32'h1);
        chk(pf_addr == 32'h8300, "R10", "head while stalled", pf_addr, 32'h8300);
        repeat (3) @(negedge clk);
        chk(pf_addr == 32'h8300, "R10", "head held", pf_addr, 32'h8300);
        pf_ready = 1'b1;
        begin
            logic [31:0] exp_q [4];
            int got;
            exp_q[0] = 32'h8300;
            exp_q[1] = 32'h8400;
            exp_q[2] = 32'h8400;
            exp_q[3] = 32'h8500;
            got = 0;
            for (int k = 0; k < 7; k++) begin
                if (pf_valid) begin
                    if (got < 4) begin
                        chk(pf_addr == exp_q[got], "R10", "drain order", pf_addr, exp_q[got]);
                    end
                    got++;
                end
                @(negedge clk);
            end
            chk(got == 4, "R10", "entries after drop", 32'(got), 32'h4);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule